// File: doc/BRIEF.md
# Instruction Prefix Extension Register

This block sits next to the decode stage of a 16-bit processor that retires one instruction per clock. Some instructions cannot carry all of their operand data in their own 16 bits. A prefix instruction therefore runs first and loads a byte of data into one of several prefix slots. The instruction that follows then sees that byte as the upper half of its immediate operand. The slot number gives it the high-order bits of its destination and source register indexes.

The prefix state lasts for exactly one executed instruction and then clears itself. A prefixed operation therefore takes two cycles. A separate flag reports whether a prefix was written for the current instruction. Branch decode uses that flag to choose an absolute target over a relative one. The flag counts even when the prefix byte is zero, so a target in the lowest 256 locations can still be reached as an absolute address. A stall input holds the prefix state, so its lifetime is counted in executed instructions and not in clock cycles.

Top module: `prefix_ext`

## Requirements
- R1: When a prefix was written by the previous executed instruction, `operand` equals the stored prefix byte in bits 15:8 and the current `imm_lo` in bits 7:0. For example, prefix 12h followed by immediate 34h gives 1234h.
- R2: When no prefix was written by the previous executed instruction, bits 15:8 of `operand` are zero, and the index extension bits in `dst_idx` and `src_idx` are zero.
- R3: Prefix data, slot and flag are applied to one executed instruction only. On the next unstalled clock edge without a prefix write, they all return to zero.
- R4: `branch_abs` is 1 exactly when a prefix was written by the previous executed instruction. This holds even when the written byte is 00h.
- R5: `dst_idx` is `{slot bit 0, dst_lo}`. Bit 0 of the stored slot number supplies bit 3 and selects destination indexes 08h to 0Fh.
- R6: `src_idx` is `{slot bit 1, src_lo}`. Bit 1 of the stored slot number supplies bit 4 and selects source indexes 10h to 1Fh.
- R7: A prefix write that directly follows another prefix write replaces the earlier byte and slot.
- R8: While `stall` is 1, the prefix state does not change. A prefix write presented during a stall is ignored.
- R9: A synchronous `rst` clears the prefix byte, the slot and the flag. This takes precedence over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds prefix state; the current instruction does not execute |
| pfx_wr | input | 1 | Current instruction is a prefix write |
| pfx_slot | input | 2 | Prefix slot number; bit 0 extends the destination index, bit 1 the source index |
| pfx_data | input | 8 | Prefix byte to store |
| imm_lo | input | 8 | Low immediate byte of the current instruction |
| dst_lo | input | 3 | Short destination index of the current instruction |
| src_lo | input | 4 | Short source index of the current instruction |
| operand | output | 16 | Widened immediate operand |
| dst_idx | output | 4 | Extended destination index |
| src_idx | output | 5 | Extended source index |
| branch_abs | output | 1 | A prefix applies to this instruction; branch target is absolute |

## Verification
The hardest case to reach is a prefix that must survive a run of stalled cycles. Fresh prefix writes arrive during the stall and must be ignored. The prefix must then apply to exactly one executed instruction and disappear. Directed sequences build this case, and also a zero-valued prefix ahead of a branch and a prefix write arriving together with a reset. Seeded random traffic then mixes writes, stalls and resets at rates that often put stalls and back-to-back writes next to each other. A bench-side model predicts each output.

// File: rtl/prefix_ext.sv
module prefix_ext #(
  parameter int PFX_W    = 8,
  parameter int IMM_LO_W = 8,
  parameter int DST_LO_W = 3,
  parameter int SRC_LO_W = 4,
  localparam int OP_W    = PFX_W + IMM_LO_W,
  localparam int DST_W   = DST_LO_W + 1,
  localparam int SRC_W   = SRC_LO_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stall,
  input  logic                pfx_wr,
  input  logic [1:0]          pfx_slot,
  input  logic [PFX_W-1:0]    pfx_data,
  input  logic [IMM_LO_W-1:0] imm_lo,
  input  logic [DST_LO_W-1:0] dst_lo,
  input  logic [SRC_LO_W-1:0] src_lo,
  output logic [OP_W-1:0]     operand,
  output logic [DST_W-1:0]    dst_idx,
  output logic [SRC_W-1:0]    src_idx,
  output logic                branch_abs
);

  logic [PFX_W-1:0] hold_byte;
  logic [1:0]       hold_slot;
  logic             hold_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_byte <= '0;
      hold_slot <= '0;
      hold_vld  <= 1'b0;
    end else if (!stall) begin
      hold_byte <= pfx_wr ? pfx_data : '0;
      hold_slot <= pfx_wr ? pfx_slot : 2'b00;
      hold_vld  <= pfx_wr;
    end
  end

  assign operand    = {hold_byte, imm_lo};
  assign dst_idx    = {hold_slot[0], dst_lo};
  assign src_idx    = {hold_slot[1], src_lo};
  assign branch_abs = hold_vld;

  // R3
  expire_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !pfx_wr) |=> (!branch_abs && operand[OP_W-1:IMM_LO_W] == '0));

  // R1
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && pfx_wr) |=> (branch_abs && operand[OP_W-1:IMM_LO_W] == $past(pfx_data)));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(hold_byte) && $stable(hold_slot) && $stable(branch_abs)));

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !branch_abs |-> (operand[OP_W-1:IMM_LO_W] == '0 && !dst_idx[DST_W-1] && !src_idx[SRC_W-1]));

  // R5
  dst_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && pfx_wr) |=> (dst_idx[DST_W-1] == $past(pfx_slot[0])));

  // R6
  src_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && pfx_wr) |=> (src_idx[SRC_W-1] == $past(pfx_slot[1])));

endmodule

// File: tb/test_prefix_ext.sv
`timescale 1ns/1ps
module test_prefix_ext;
  logic       clk = 1'b0;
  logic       rst, stall, pfx_wr;
  logic [1:0] pfx_slot;
  logic [7:0] pfx_data, imm_lo;
  logic [2:0] dst_lo;
  logic [3:0] src_lo;
  logic [15:0] operand;
  logic [3:0] dst_idx;
  logic [4:0] src_idx;
  logic       branch_abs;

  prefix_ext i_prefix_ext (
    .clk(clk), .rst(rst), .stall(stall), .pfx_wr(pfx_wr), .pfx_slot(pfx_slot),
    .pfx_data(pfx_data), .imm_lo(imm_lo), .dst_lo(dst_lo), .src_lo(src_lo),
    .operand(operand), .dst_idx(dst_idx), .src_idx(src_idx), .branch_abs(branch_abs)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] m_byte;
  logic [1:0] m_slot;
  logic       m_vld;

  function automatic logic [15:0] exp_operand(input logic [7:0] b, input logic [7:0] lo);
    return {b, lo};
  endfunction

  task automatic chk(input string tag, input string ctx, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %h expected %h", tag, ctx, act, exp);
    end
  endtask

  task automatic cyc(input string ctx, input logic r, input logic st, input logic wr,
                     input logic [1:0] sl, input logic [7:0] d, input logic [7:0] il,
                     input logic [2:0] dl, input logic [3:0] srl);
    @(negedge clk);
    rst = r; stall = st; pfx_wr = wr; pfx_slot = sl; pfx_data = d;
    imm_lo = il; dst_lo = dl; src_lo = srl;
    #1;
    chk(m_vld ? "R1" : "R2", ctx, operand, exp_operand(m_vld ? m_byte : 8'h00, il));
    chk("R5", ctx, {12'h0, dst_idx}, {12'h0, m_vld & m_slot[0], dl});
    chk("R6", ctx, {11'h0, src_idx}, {11'h0, m_vld & m_slot[1], srl});
    chk("R4", ctx, {15'h0, branch_abs}, {15'h0, m_vld});
    @(posedge clk);
    if (r) begin
      m_byte = 8'h00; m_slot = 2'b00; m_vld = 1'b0;
    end else if (!st) begin
      m_byte = wr ? d : 8'h00;
      m_slot = wr ? sl : 2'b00;
      m_vld  = wr;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    m_byte = 8'h00; m_slot = 2'b00; m_vld = 1'b0;
    rst = 1'b1; stall = 1'b0; pfx_wr = 1'b0; pfx_slot = 2'b00; pfx_data = 8'h00;
    imm_lo = 8'h00; dst_lo = 3'd0; src_lo = 4'd0;
    @(posedge clk); @(posedge clk);
    // R9 reset state
    cyc("R9 after reset", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h5A, 3'd7, 4'd15);
    // R1 12h then 34h gives 1234h
    cyc("R1 prefix 12h", 1'b0, 1'b0, 1'b1, 2'b00, 8'h12, 8'h00, 3'd0, 4'd0);
    cyc("R1 load 34h", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h34, 3'd2, 4'd3);
    chk("R1", "1234h result", operand, 16'h1234);
    // R3 gone after one instruction
    cyc("R3 expired", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h34, 3'd2, 4'd3);
    // R4 zero prefix still absolute
    cyc("R4 prefix 00h", 1'b0, 1'b0, 1'b1, 2'b00, 8'h00, 8'h00, 3'd0, 4'd0);
    cyc("R4 branch 00xxh", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h42, 3'd0, 4'd0);
    // R5 R6 both extension bits plus byte in one write
    cyc("R5 R6 slot 3", 1'b0, 1'b0, 1'b1, 2'b11, 8'hA5, 8'h00, 3'd0, 4'd0);
    cyc("R5 R6 extended idx", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h0F, 3'd5, 4'd9);
    // R7 back-to-back replaces
    cyc("R7 first", 1'b0, 1'b0, 1'b1, 2'b01, 8'hAB, 8'h00, 3'd0, 4'd0);
    cyc("R7 second", 1'b0, 1'b0, 1'b1, 2'b10, 8'hCD, 8'h11, 3'd1, 4'd1);
    cyc("R7 replaced", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h22, 3'd6, 4'd6);
    // R8 stall holds and ignores writes
    cyc("R8 write", 1'b0, 1'b0, 1'b1, 2'b01, 8'h77, 8'h00, 3'd0, 4'd0);
    for (int k = 0; k < 4; k++)
      cyc("R8 stalled write", 1'b0, 1'b1, 1'b1, 2'b10, 8'h99, 8'h01, 3'd3, 4'd3);
    cyc("R8 held value", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h66, 3'd4, 4'd4);
    chk("R8", "held byte", operand, 16'h7766);
    cyc("R3 after stall", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h66, 3'd4, 4'd4);
    // R9 reset beats write
    cyc("R9 write", 1'b0, 1'b0, 1'b1, 2'b11, 8'hEE, 8'h00, 3'd0, 4'd0);
    cyc("R9 reset with write", 1'b1, 1'b0, 1'b1, 2'b11, 8'hDD, 8'h00, 3'd0, 4'd0);
    cyc("R9 cleared", 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h3C, 3'd7, 4'd15);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      cyc("random", ($urandom % 60) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0,
          2'($urandom), 8'($urandom), 8'($urandom), 3'($urandom), 4'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule